// File: doc/BRIEF.md
# Receive Frame Checksum Offload Engine

This block sits inline in a MAC receive path and works on a byte-wide Ethernet frame stream. Each byte comes with valid, start-of-frame and end-of-frame markers. The block walks the frame header: the two 6-byte station addresses, up to two 802.1Q tags and the type/length field. In the second operating mode it also skips an 8-byte LLC/SNAP header that follows a length value. It then forms a 16-bit end-around-carry sum over the layer-3 bytes and leaves out the trailing 4-byte FCS.

Every received byte passes to the output unchanged, one cycle later. When the engine is enabled for a frame, two extra bytes follow the final frame byte: the sum, high byte first. The length reported with the end-of-frame marker grows by two to cover them. While these two bytes are emitted, the input is held off through a ready signal.

The enable and mode inputs are sampled only on the start-of-frame byte. A change in the middle of a frame therefore cannot alter a frame that is already in flight.

Top module: `rx_csum_offload`

## Requirements
- R1: Every accepted input byte appears on the output unchanged and in order, exactly one cycle after it is accepted. The first byte of a frame carries the start marker.
- R2: For a frame that starts with the enable input low:
  - no bytes are appended and the input is never stalled;
  - the end marker comes with the final frame byte;
  - the reported length equals the number of frame bytes.
- R3: For a frame that starts with the enable input high, two bytes follow the final frame byte: the sum's bits 15:8 first, then bits 7:0. The end marker comes with the second of them.
- R4: When the engine is enabled, the length presented with the end marker is the frame byte count plus two.
- R5: Summed bytes are taken in pairs. The first byte of a pair is bits 7:0 of a 16-bit word and the second is bits 15:8. Each word is added to the running 16-bit sum, and any carry out of bit 15 is added back in. The result is not complemented.
- R6: When the number of summed bytes is odd, the last byte forms a word with 0x00 as its bits 15:8.
- R7: The final 4 bytes of every frame are left out of the sum but still pass to the output. A frame with no bytes between the header and those 4 yields a sum of 0x0000.
- R8: Summing starts after the 12 address bytes and the 2-byte type field. A type value of 0x8100 marks a tag: the 2 bytes after it are skipped and another type field follows. At most two tags are recognised this way.
- R9: A third 0x8100 value is taken as the frame's type field, and summing begins at the byte directly after it.
- R10: With the mode input high at frame start, a type/length value below 0x0600 is followed by 8 skipped bytes before summing begins. With the mode input low, or a value of 0x0600 or above, no bytes are skipped.
- R11: Changing the enable or mode input after the start byte has no effect on the current frame.
- R12: `in_ready` is high after reset and at all times except the two cycles in which the appended bytes are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Append the checksum to frames starting while high |
| cfg_snap_mode | input | 1 | Skip an 8-byte LLC/SNAP header after a length value |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Output byte valid |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of the emitted frame |
| out_data | output | 8 | Output byte |
| out_len | output | 16 | Emitted frame length, meaningful with `out_eof` |

## Verification
Directed frames are chosen so that a header-walking fault moves the summing start point:
- frames with zero, two and three 0x8100 tags;
- length-field frames run in both modes, and a type frame run in snap mode.

A 5-byte payload with a known sum of 0x0609 separates the pair byte order and the odd-byte padding. An all-0xFF payload forces the end-around carry. Two frames that differ only in their FCS must produce the same checksum, and a header-only frame must produce zero. Randomly built frames mix tag counts, field kinds, payload lengths, idle gaps and both enable and mode settings. A mid-frame flip of the controls shows that the settings are latched at frame start.

// File: rtl/rx_csum_pkg.sv
package rx_csum_pkg;

    localparam int BYTE_W     = 8;
    localparam int SUM_W      = 16;
    localparam int ADDR_BYTES = 12;
    localparam int TYPE_BYTES = 2;
    localparam int TAG_BYTES  = 2;

    typedef enum logic [2:0] {
        HW_ADDR,
        HW_TYPE,
        HW_TAG,
        HW_SNAP,
        HW_BODY
    } hdr_phase_e;

    typedef enum logic [1:0] {
        EM_PASS,
        EM_HI,
        EM_LO
    } emit_phase_e;

    // 16-bit addition with the carry out of bit 15 wrapped back into bit 0
    function automatic logic [SUM_W-1:0] wrap_add(input logic [SUM_W-1:0] a,
                                                   input logic [SUM_W-1:0] b);
        logic [SUM_W:0] raw;
        raw = {1'b0, a} + {1'b0, b};
        return raw[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, raw[SUM_W]};
    endfunction

endpackage

// File: rtl/rx_csum_hdr_walk.sv
module rx_csum_hdr_walk
    import rx_csum_pkg::*;
#(
    parameter int          MAX_TAGS   = 2,
    parameter int          SNAP_BYTES = 8,
    parameter logic [15:0] TAG_TPID   = 16'h8100,
    parameter logic [15:0] LEN_LIMIT  = 16'h0600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              sof,
    input  logic [BYTE_W-1:0] data,
    input  logic              snap_mode,
    output logic              body
);
    localparam int SPAN  = (SNAP_BYTES > ADDR_BYTES) ? SNAP_BYTES : ADDR_BYTES;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam int TAG_W = $clog2(MAX_TAGS + 1);

    hdr_phase_e        ph;
    logic [CNT_W-1:0]  cnt;
    logic [TAG_W-1:0]  tags;
    logic [BYTE_W-1:0] first_half;
    logic [15:0]       field;

    assign field = {first_half, data};
    assign body  = stb && !sof && (ph == HW_BODY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= HW_ADDR;
            cnt        <= '0;
            tags       <= '0;
            first_half <= '0;
        end else if (stb) begin
            if (sof) begin
                ph   <= HW_ADDR;
                cnt  <= CNT_W'(1);
                tags <= '0;
            end else begin
                unique case (ph)
                    HW_ADDR: begin
                        if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                            ph  <= HW_TYPE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    HW_TYPE: begin
                        if (cnt == '0) begin
                            first_half <= data;
                            cnt        <= CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            if (field == TAG_TPID && tags < TAG_W'(MAX_TAGS)) begin
                                ph   <= HW_TAG;
                                tags <= tags + TAG_W'(1);
                            end else if (snap_mode && field < LEN_LIMIT) begin
                                ph <= HW_SNAP;
                            end else begin
                                ph <= HW_BODY;
                            end
                        end
                    end
                    HW_TAG: begin
                        if (cnt == CNT_W'(TAG_BYTES - 1)) begin
                            ph  <= HW_TYPE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    HW_SNAP: begin
                        if (cnt == CNT_W'(SNAP_BYTES - 1)) begin
                            ph  <= HW_BODY;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: ph <= HW_BODY;
                endcase
            end
        end
    end

    // R8: the tag counter never passes the recognised limit
    p_tag_limit_r8: assert property (@(posedge clk) disable iff (rst)
        tags <= TAG_W'(MAX_TAGS));

    // R9: once summing has begun, later bytes of the frame stay in the body
    p_body_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ph == HW_BODY && stb && !sof) |=> (ph == HW_BODY));

endmodule

// File: rtl/rx_csum_tail_hold.sv
module rx_csum_tail_hold
    import rx_csum_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    output logic              pop_stb,
    output logic [BYTE_W-1:0] pop_data
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] line [DEPTH];
    logic [FILL_W-1:0] fill;

    assign pop_stb  = push && (fill == FILL_W'(DEPTH));
    assign pop_data = line[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill <= '0;
        end else if (push && fill != FILL_W'(DEPTH)) begin
            fill <= fill + FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) line[0] <= din;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (push) line[g] <= line[g-1];
        end
    end

    // R7: a new frame starts with an empty window, so its first bytes are held
    p_window_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fill == '0));

endmodule

// File: rtl/rx_csum_sum.sv
module rx_csum_sum
    import rx_csum_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_stb,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [SUM_W-1:0]  csum
);
    logic [SUM_W-1:0]  acc;
    logic              half;
    logic [BYTE_W-1:0] lo;

    assign csum = half ? wrap_add(acc, {{BYTE_W{1'b0}}, lo}) : acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc  <= '0;
            half <= 1'b0;
            lo   <= '0;
        end else if (add_stb) begin
            if (half) begin
                acc  <= wrap_add(acc, {add_byte, lo});
                half <= 1'b0;
            end else begin
                lo   <= add_byte;
                half <= 1'b1;
            end
        end
    end

    // R6: every summed byte alternates between the low and high slot of a word
    p_pair_alt_r6: assert property (@(posedge clk) disable iff (rst)
        (add_stb && !clr) |=> (half != $past(half)));

endmodule

// File: rtl/rx_csum_offload.sv
module rx_csum_offload
    import rx_csum_pkg::*;
#(
    parameter int          LEN_W      = 16,
    parameter int          FCS_BYTES  = 4,
    parameter int          MAX_TAGS   = 2,
    parameter int          SNAP_BYTES = 8,
    parameter logic [15:0] TAG_TPID   = 16'h8100,
    parameter logic [15:0] LEN_LIMIT  = 16'h0600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_snap_mode,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [7:0]       out_data,
    output logic [LEN_W-1:0] out_len
);
    localparam logic [LEN_W-1:0] APPEND_LEN = LEN_W'(SUM_W / BYTE_W);

    emit_phase_e      em;
    logic             in_fire;
    logic             en_q, mode_q, eff_en, eff_mode;
    logic [LEN_W-1:0] len_q, len_cur;
    logic             body;
    logic             pop_stb;
    logic [7:0]       pop_data;
    logic [SUM_W-1:0] csum;

    assign in_ready = (em == EM_PASS);
    assign in_fire  = in_valid && in_ready;
    assign eff_en   = in_sof ? cfg_enable    : en_q;
    assign eff_mode = in_sof ? cfg_snap_mode : mode_q;
    assign len_cur  = in_sof ? LEN_W'(1) : len_q + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            len_q  <= '0;
        end else if (in_fire) begin
            len_q <= len_cur;
            if (in_sof) begin
                en_q   <= cfg_enable;
                mode_q <= cfg_snap_mode;
            end
        end
    end

    rx_csum_hdr_walk #(
        .MAX_TAGS  (MAX_TAGS),
        .SNAP_BYTES(SNAP_BYTES),
        .TAG_TPID  (TAG_TPID),
        .LEN_LIMIT (LEN_LIMIT)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .stb      (in_fire),
        .sof      (in_sof),
        .data     (in_data),
        .snap_mode(eff_mode),
        .body     (body)
    );

    rx_csum_tail_hold #(.DEPTH(FCS_BYTES)) u_tail (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_fire && in_sof),
        .push    (body),
        .din     (in_data),
        .pop_stb (pop_stb),
        .pop_data(pop_data)
    );

    rx_csum_sum u_sum (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_fire && in_sof),
        .add_stb (pop_stb),
        .add_byte(pop_data),
        .csum    (csum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            em        <= EM_PASS;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
            out_len   <= '0;
        end else begin
            unique case (em)
                EM_PASS: begin
                    out_valid <= in_fire;
                    out_sof   <= in_fire && in_sof;
                    out_eof   <= in_fire && in_eof && !eff_en;
                    out_data  <= in_data;
                    if (in_fire && in_eof) begin
                        out_len <= eff_en ? len_cur + APPEND_LEN : len_cur;
                        if (eff_en) em <= EM_HI;
                    end
                end
                EM_HI: begin
                    out_valid <= 1'b1;
                    out_sof   <= 1'b0;
                    out_eof   <= 1'b0;
                    out_data  <= csum[15:8];
                    em        <= EM_LO;
                end
                default: begin
                    out_valid <= 1'b1;
                    out_sof   <= 1'b0;
                    out_eof   <= 1'b1;
                    out_data  <= csum[7:0];
                    em        <= EM_PASS;
                end
            endcase
        end
    end

    // R1: an accepted byte is on the output, unchanged, in the next cycle
    p_pass_through_r1: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> (out_valid && out_data == $past(in_data) && out_sof == $past(in_sof)));

    // R2: a disabled frame ends on its own last byte and never stalls the input
    p_no_append_r2: assert property (@(posedge clk) disable iff (rst)
        (in_fire && in_eof && !eff_en) |=> (out_eof && in_ready));

    // R3: an enabled frame end stalls the input right away
    p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
        (in_fire && in_eof && eff_en) |=> !in_ready);

    // R3: the end marker only comes with a valid byte
    p_eof_valid_r3: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> out_valid);

    // R12: the stall lasts a second cycle and is followed by a ready cycle
    p_stall_two_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |=> (!in_ready && out_valid));

    p_ready_back_r12: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !$past(in_ready)) |=> in_ready);

endmodule

// File: tb/rx_csum_offload_tb.sv
module rx_csum_offload_tb;
    localparam int CLK_PERIOD = 10;

    typedef byte unsigned bq_t[$];

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_enable, cfg_snap_mode;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic [15:0] out_len;

    int n_run  = 0;
    int n_fail = 0;

    byte unsigned got[$];
    int           got_len;
    bit           got_done;
    int           stall_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_csum_offload u_dut (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_snap_mode(cfg_snap_mode),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_data(out_data), .out_len(out_len)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (!in_ready) stall_cnt++;
            if (out_valid) begin
                got.push_back(out_data);
                if (out_eof) begin
                    got_len  = int'(out_len);
                    got_done = 1'b1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Reference: walk the header, then sum with the carry wrapped around
    function automatic logic [15:0] exp_sum(input bq_t f, input bit mode);
        int p = 12;
        int vl = 0;
        int t = 0;
        int s = 0;
        int stop;
        stop = f.size() - 4;
        while (1) begin
            if (p + 2 > f.size()) return 16'h0000;
            t = {f[p], f[p+1]};
            p += 2;
            if (t == 16'h8100 && vl < 2) begin
                p += 2;
                vl++;
            end else begin
                break;
            end
        end
        if (mode && t < 16'h0600) p += 8;
        for (int i = p; i < stop; i += 2) begin
            int w;
            w = f[i];
            if (i + 1 < stop) w += f[i+1] * 256;
            s += w;
            if (s > 65535) s -= 65535;
        end
        return s[15:0];
    endfunction

    // kind 0: type 0x0800, 1: length field + 8 SNAP bytes, 2: type 0x86DD
    function automatic bq_t build(input int ntags, input int kind, input int plen);
        bq_t f;
        for (int i = 0; i < 12; i++) f.push_back(8'($urandom));
        for (int i = 0; i < ntags; i++) begin
            f.push_back(8'h81); f.push_back(8'h00);
            f.push_back(8'($urandom)); f.push_back(8'($urandom));
        end
        if (kind == 1) begin
            int l;
            l = $urandom_range(0, 16'h05FF);
            f.push_back(8'(l >> 8)); f.push_back(8'(l));
            for (int i = 0; i < 8; i++) f.push_back(8'($urandom));
        end else if (kind == 2) begin
            f.push_back(8'h86); f.push_back(8'hDD);
        end else begin
            f.push_back(8'h08); f.push_back(8'h00);
        end
        for (int i = 0; i < plen + 4; i++) f.push_back(8'($urandom));
        return f;
    endfunction

    task automatic run_frame(input bq_t f, input bit en, input bit mode,
                             input bit flip, input string tag);
        logic [15:0] es;
        int          last;
        bit          ok;
        got.delete();
        got_done  = 1'b0;
        stall_cnt = 0;
        cfg_enable    = en;
        cfg_snap_mode = mode;
        last = f.size() - 1;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 4) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            while (!in_ready) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == last);
            in_data  = f[i];
            if (flip && i == 3) begin
                cfg_enable    = !en;
                cfg_snap_mode = !mode;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        for (int k = 0; k < 20 && !got_done; k++) @(negedge clk);
        cfg_enable = en; cfg_snap_mode = mode;

        es = exp_sum(f, mode);
        ok = got.size() >= f.size();
        for (int i = 0; i < f.size() && ok; i++) if (got[i] != f[i]) ok = 0;
        check(ok, "R1", "frame bytes passed through", got.size(), f.size());
        if (en) begin
            ok = got.size() == f.size() + 2;
            check(ok && {got[f.size()], got[f.size()+1]} == es, tag, "appended checksum",
                  ok ? int'({got[f.size()], got[f.size()+1]}) : -1, int'(es));
            check(got_len == f.size() + 2, "R4", "length with checksum", got_len, f.size() + 2);
            check(stall_cnt == 2, "R12", "stall cycles", stall_cnt, 2);
        end else begin
            check(got.size() == f.size(), "R2", "no appended bytes", got.size(), f.size());
            check(got_len == f.size(), "R2", "unchanged length", got_len, f.size());
            check(stall_cnt == 0, "R2", "no stall", stall_cnt, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bq_t f, g;
        int  n;
        void'($urandom(32'h5EED_C0DE));
        rst = 1'b1;
        cfg_enable = 1'b0; cfg_snap_mode = 1'b0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R12", "reset out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R12", "reset in_ready", in_ready, 1);

        // R6: payload 01..05 -> words 0x0201, 0x0403, 0x0005 -> 0x0609
        f = build(0, 0, 0);
        for (int i = 0; i < 4; i++) void'(f.pop_back());
        for (int i = 1; i <= 5; i++) f.push_back(8'(i));
        for (int i = 0; i < 4; i++) f.push_back(8'hA5);
        run_frame(f, 1, 0, 0, "R6");
        n = f.size();
        check({got[n], got[n+1]} == 16'h0609, "R3", "high byte first", {got[n], got[n+1]}, 16'h0609);
        run_frame(f, 0, 0, 0, "R2");

        // R5: FF FF FF FF 01 00 -> 0xFFFF + 0xFFFF wraps to 0xFFFF, + 0x0001 wraps to 0x0001
        f = build(0, 2, 0);
        for (int i = 0; i < 4; i++) void'(f.pop_back());
        f.push_back(8'hFF); f.push_back(8'hFF); f.push_back(8'hFF); f.push_back(8'hFF);
        f.push_back(8'h01); f.push_back(8'h00);
        for (int i = 0; i < 4; i++) f.push_back(8'h3C);
        run_frame(f, 1, 0, 0, "R5");
        n = f.size();
        check({got[n], got[n+1]} == 16'h0001, "R5", "end-around carry", {got[n], got[n+1]}, 16'h0001);

        // R7: frames differing only in FCS give the same checksum
        f = build(1, 0, 9);
        g = f;
        for (int i = 1; i <= 4; i++) g[g.size()-i] = ~g[g.size()-i];
        run_frame(f, 1, 0, 0, "R7");
        n = got_len;
        run_frame(g, 1, 0, 0, "R7");
        check(exp_sum(f, 0) == exp_sum(g, 0), "R7", "FCS ignored (reference)", 0, 0);
        // R7: header plus FCS only -> zero
        run_frame(build(0, 0, 0), 1, 0, 0, "R7");
        n = got.size();
        check({got[n-2], got[n-1]} == 16'h0000, "R7", "empty body sum", {got[n-2], got[n-1]}, 0);

        run_frame(build(2, 0, 7), 1, 0, 0, "R8");
        run_frame(build(3, 0, 8), 1, 0, 0, "R9");
        run_frame(build(3, 1, 6), 1, 1, 0, "R9");
        run_frame(build(0, 1, 11), 1, 1, 0, "R10");
        run_frame(build(0, 1, 11), 1, 0, 0, "R10");
        run_frame(build(1, 2, 10), 1, 1, 0, "R10");
        run_frame(build(0, 1, 5), 1, 1, 1, "R11");
        run_frame(build(1, 0, 5), 0, 0, 1, "R11");

        for (int r = 0; r < 60; r++) begin
            run_frame(build($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 40)),
                      1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0), "R5");
        end

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule